// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block hands the processor's bus to an external master, such as a DMA engine, on request. The request input is asynchronous. It is resynchronised, and the block then stalls the processor's bus sequencer so that no new cycle starts. Any cycle already running is allowed to finish. After that the acknowledge output is raised.

Half a clock after the acknowledge rises, a falling-edge register stage drops the address, data and control output enables. The pad drivers then go to high impedance and the external master can drive the bus.

When the request is withdrawn, the acknowledge falls first. The enables come back on half a clock after that, so two drivers never share the bus. The sequencer stall is released once the enables are active again. If the request is withdrawn while the block is still waiting for the running cycle to end, no grant is made and the block returns to idle.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While reset is active and directly after it, `hold_ack` is 0, `seq_stall` is 0 and all three enables (`addr_oe`, `data_oe`, `ctrl_oe`) are 1.
- R2: `hold_req` passes through a SYNC_STAGES-flop synchronizer. With `cyc_busy` low, `hold_ack` rises on the (SYNC_STAGES+1)-th rising edge after `hold_req` goes high, and not earlier.
- R3: No grant is made while a cycle is in progress. `hold_ack` stays 0 while `cyc_busy` is 1, and rises on the first rising edge at which `cyc_busy` is sampled 0.
- R4: The three enables drop to 0 on the falling clock edge that follows the rise of `hold_ack`, half a clock later. At the rising edge itself they are still 1.
- R5: Whenever `hold_ack` is 1, all three enables are 0 and `seq_stall` is 1.
- R6: `seq_stall` is 1 from the cycle in which the synchronized request is seen high until the rising edge after the enables have been restored. It is 0 whenever the block is idle with no request.
- R7: After `hold_req` falls, `hold_ack` drops on the (SYNC_STAGES+1)-th rising edge. The enables stay 0 at that edge and return to 1 on the next falling edge.
- R8: If `hold_req` is withdrawn before any grant while `cyc_busy` is held 1, `hold_ack` never rises, the enables stay 1, and `seq_stall` returns to 0 on the (SYNC_STAGES+1)-th rising edge after the withdrawal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the float stage uses the falling edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| hold_req | input | 1 | Asynchronous bus request from the external master |
| cyc_busy | input | 1 | High while the bus sequencer has a cycle in progress |
| hold_ack | output | 1 | Bus granted to the external master |
| seq_stall | output | 1 | Holds off the bus sequencer from starting cycles |
| addr_oe | output | 1 | Address bus output enable, 1 = drive |
| data_oe | output | 1 | Data bus output enable, 1 = drive |
| ctrl_oe | output | 1 | Control bus output enable, 1 = drive |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. Every latency it expects is derived from that value, so a synchronizer depth that ignores the parameter shows up as an off-by-one edge. Checks sample both just after rising edges and just after falling edges. This makes the half-clock placement of the float and restore points observable, including the rising edge at which the acknowledge has changed but the enables have not yet moved.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE    = 2'd0,
    ARB_DRAIN   = 2'd1,
    ARB_GRANT   = 2'd2,
    ARB_RESTORE = 2'd3
  } arb_state_t;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import bus_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic cyc_busy,
  output logic ack,
  output logic stall
);
  arb_state_t state_q, state_d;
  logic       ack_q, ack_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE:    if (req_s) state_d = cyc_busy ? ARB_DRAIN : ARB_GRANT;
      ARB_DRAIN:   if (!req_s) state_d = ARB_IDLE;
                   else if (!cyc_busy) state_d = ARB_GRANT;
      ARB_GRANT:   if (!req_s) state_d = ARB_RESTORE;
      ARB_RESTORE: state_d = ARB_IDLE;
      default:     state_d = ARB_IDLE;
    endcase
    ack_d = (state_d == ARB_GRANT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end

  assign ack   = ack_q;
  assign stall = (state_q != ARB_IDLE) || req_s;

  assert_no_grant_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && cyc_busy) |=> !ack);
  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(req_s));
  assert_stall_in_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> stall);
endmodule

// File: rtl/float_stage.sv
module float_stage #(
  parameter int N_OE = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack,
  input  logic            stall,
  output logic [N_OE-1:0] oe
);
  logic [N_OE-1:0] float_q, float_d;

  always_comb begin
    float_d = {N_OE{ack}};
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) float_q <= '0;
    else        float_q <= float_d;
  end

  assign oe = ~float_q;

  assert_one_driver_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (oe == '0));
  assert_restore_after_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack) |-> (oe == '1));
  assert_idle_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> (oe == '1));
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic cyc_busy,
  output logic hold_ack,
  output logic seq_stall,
  output logic addr_oe,
  output logic data_oe,
  output logic ctrl_oe
);
  localparam int N_OE = 3;

  logic            req_s;
  logic            ack;
  logic            stall;
  logic [N_OE-1:0] oe;

  hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (hold_req),
    .sync_out (req_s)
  );

  hold_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_s    (req_s),
    .cyc_busy (cyc_busy),
    .ack      (ack),
    .stall    (stall)
  );

  float_stage #(.N_OE(N_OE)) u_float (
    .clk   (clk),
    .rst_n (rst_n),
    .ack   (ack),
    .stall (stall),
    .oe    (oe)
  );

  assign hold_ack  = ack;
  assign seq_stall = stall;
  assign addr_oe   = oe[2];
  assign data_oe   = oe[1];
  assign ctrl_oe   = oe[0];
endmodule

// File: tb/tb_bus_hold_arbiter.sv
module tb_bus_hold_arbiter;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_req = 1'b0;
  logic cyc_busy = 1'b0;
  logic hold_ack, seq_stall, addr_oe, data_oe, ctrl_oe;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  bus_hold_arbiter #(.SYNC_STAGES(S)) dut (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .cyc_busy(cyc_busy),
    .hold_ack(hold_ack), .seq_stall(seq_stall),
    .addr_oe(addr_oe), .data_oe(data_oe), .ctrl_oe(ctrl_oe)
  );

  // observed vector: {hold_ack, seq_stall, addr_oe, data_oe, ctrl_oe}
  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {hold_ack, seq_stall, addr_oe, data_oe, ctrl_oe};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: ack,stall,oe = %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic half();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1 chk("R1 during reset", 5'b00111);
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 after reset", 5'b00111);
  endtask

  // enters with hold granted, at posedge+2
  task automatic release_and_check();
    hold_req = 1'b0;
    step(S);
    chk("R7 ack held before sync", 5'b11000);
    step(1);
    chk("R7 ack dropped, enables still off", 5'b01000);
    half();
    chk("R7 enables restored on falling edge", 5'b01111);
    step(1);
    chk("R6 stall released", 5'b00111);
  endtask

  task automatic t_grant_idle();
    hold_req = 1'b1;
    cyc_busy = 1'b0;
    step(S);
    chk("R6 stall on sync, R2 no early ack", 5'b01111);
    step(1);
    chk("R2 ack rises, R4 enables not yet off", 5'b11111);
    half();
    chk("R4 R5 floated half clock later", 5'b11000);
    step(1);
    release_and_check();
  endtask

  task automatic t_grant_busy();
    hold_req = 1'b1;
    cyc_busy = 1'b1;
    step(S + 1);
    chk("R3 no grant while busy", 5'b01111);
    step(4);
    chk("R3 still no grant while busy", 5'b01111);
    cyc_busy = 1'b0;
    step(1);
    chk("R3 grant on first idle edge", 5'b11111);
    half();
    chk("R4 R5 floated after busy grant", 5'b11000);
    step(1);
    release_and_check();
  endtask

  task automatic t_abort_drain();
    hold_req = 1'b1;
    cyc_busy = 1'b1;
    step(S + 2);
    chk("R8 draining", 5'b01111);
    hold_req = 1'b0;
    step(S);
    half();
    chk("R8 no float during drain", 5'b01111);
    step(1);
    chk("R8 back to idle, no grant", 5'b00111);
    cyc_busy = 1'b0;
    step(3);
    chk("R8 idle stays without request", 5'b00111);
  endtask

  initial begin
    t_reset();
    t_grant_idle();
    step(2);
    t_grant_busy();
    step(2);
    t_abort_drain();
    step(2);
    t_grant_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule